// File: doc/BRIEF.md
# Supply-Control Register with I2C Target

This block is the host-facing control point for one section of a two-section supply controller. It is a two-wire serial target that holds a single control register and a single status byte. A host writes one byte to set the five control lines of the section: output enable, voltage select, line-loss compensation, tone-transmit enable and continuous-tone enable. A host read returns one byte. That byte combines the overtemperature and overload monitor inputs with a copy of the last output settings that were written.

The device address depends on two things. A parameter fixes the section, and a strap input picks one of the two addresses that section owns. Both sections can share one bus without conflict. SCL and SDA come in as sampled line levels from the oversampling system clock. The block pulls SDA low through a single drive-enable output, which models an open-drain pad. A synchronous active-low reset acts as the power-on reset and clears every register bit.

Top module: `supply_ctl_i2c_target`

## Requirements
- R1: The 7-bit device address is {5'b00010, SECTION, addr_strap_i}. This gives write/read bytes 0x10/0x11 or 0x12/0x13 for section 0, and 0x14/0x15 or 0x16/0x17 for section 1. The target pulls SDA low in the ninth clock when the address matches. It leaves SDA released (NACK) when the address does not match, and it ignores the rest of that transfer.
- R2: After a matching write address, the first data byte is acknowledged. Its bit 0 drives out_en_o, bit 1 out_vsel_o, bit 2 out_llc_o, bit 3 out_ttx_o and bit 4 out_ten_o. Bits 7 to 5 of the byte are ignored.
- R3: A read byte is sent MSB first. Its layout is: bit 0 echoes EN, bit 1 VSEL, bit 2 LLC, bit 3 the overtemperature flag, bit 4 the overload flag. Bits 7 to 5 read as 0.
- R4: The overtemperature and overload bits are 1 exactly when ot_mon_i and ol_mon_i were high when the read byte was loaded, at the start of that byte.
- R5: After the host NACKs a read byte, the target releases SDA and stays released until the next START.
- R6: A START or STOP that arrives before a data byte is complete abandons the transfer and leaves the control register unchanged.
- R7: Reset clears all five control outputs and releases SDA.
- R8: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_strap_i | input | 1 | Address strap, selects the upper address of the pair |
| ot_mon_i | input | 1 | Overtemperature monitor, high when junction is above 150 °C |
| ol_mon_i | input | 1 | Overload monitor, high on current limit or short |
| out_en_o | output | 1 | Output enable |
| out_vsel_o | output | 1 | Output voltage select |
| out_llc_o | output | 1 | Line-loss compensation |
| out_ttx_o | output | 1 | Tone-transmit enable |
| out_ten_o | output | 1 | Continuous-tone enable |

## Verification
The hardest case to reach is a transfer cut off partway through a data byte. The cut must land after the address has been accepted and before the byte's commit edge. The bench's host model can stop after any number of data bits and then issue a STOP, or a repeated START that begins a read. Reading back afterwards shows whether the register moved. The address sweep places a section-0 and a section-1 target on one wired-AND bus and tries every strap setting against all four addresses. This shows that exactly one target answers each address.

// File: rtl/supply_ctl_pkg.sv
// Package: shared types and field positions for the supply-control target.
// Assumes 8-bit bytes on the bus and a 5-bit control field.
package supply_ctl_pkg;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned CTL_W   = 5;
    localparam int unsigned BITCNT_W = $clog2(BYTE_W + 1);
    // Field positions in the status byte; positions above FLAG_OL read as 0.
    localparam int unsigned ECHO_W  = 3;
    localparam int unsigned FLAG_OT = 3;
    localparam int unsigned FLAG_OL = 4;

    typedef enum logic [2:0] {
        ST_IDLE,   // bus free or not yet addressed
        ST_ADDR,   // shifting in the address byte
        ST_AACK,   // driving address acknowledge
        ST_WR,     // shifting in the control byte
        ST_WACK,   // driving data acknowledge
        ST_RD,     // shifting out the status byte
        ST_RACK,   // waiting for host acknowledge
        ST_HOLD    // transfer finished or ignored, waiting for START/STOP
    } tgt_state_e;
endpackage

// File: rtl/bus_line_sync.sv
// Module: bus_line_sync
// Brings SCL and SDA into the clock domain and turns their levels into
// edge and START/STOP events. Assumes the system clock is at least
// several times faster than SCL. The idle bus level is high.
module bus_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_ff, sda_ff;
    logic       scl_prev, sda_prev;

    // Two-stage synchroniser plus one stage of history per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff   <= 2'b11;
            sda_ff   <= 2'b11;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_ff   <= {scl_ff[0], scl_i};
            sda_ff   <= {sda_ff[0], sda_i};
            scl_prev <= scl_ff[1];
            sda_prev <= sda_ff[1];
        end
    end

    // Event decode from the current and previous synchronised levels.
    always_comb begin
        scl_lvl   = scl_ff[1];
        sda_lvl   = sda_ff[1];
        scl_rise  = scl_ff[1] & ~scl_prev;
        scl_fall  = ~scl_ff[1] & scl_prev;
        start_det = scl_ff[1] & scl_prev & sda_prev & ~sda_ff[1];
        stop_det  = scl_ff[1] & scl_prev & ~sda_prev & sda_ff[1];
    end
endmodule

// File: rtl/target_byte_engine.sv
// Module: target_byte_engine
// Bit-level target protocol. It matches the address, receives one
// control byte, and sends the status byte repeatedly for as long as the
// host acknowledges. It commits a write only at the falling SCL edge
// after the eighth data bit. Assumes events come from bus_line_sync.
module target_byte_engine
    import supply_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [6:0]        dev_addr,
    input  logic [BYTE_W-1:0] status_byte,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data
);
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W);

    tgt_state_e          state;
    logic [BYTE_W-1:0]   shreg;
    logic [BITCNT_W-1:0] bit_cnt;
    logic                rnw;

    // Protocol sequencer: bus events move the state; START and STOP come first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            bit_cnt <= '0;
            rnw     <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WR: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == LAST_BIT) begin
                            if (state == ST_ADDR) begin
                                if (shreg[BYTE_W-1:1] == dev_addr) begin
                                    rnw    <= shreg[0];
                                    sda_oe <= 1'b1;
                                    state  <= ST_AACK;
                                end else begin
                                    state <= ST_HOLD;
                                end
                            end else begin
                                wr_en   <= 1'b1;
                                wr_data <= shreg;
                                sda_oe  <= 1'b1;
                                state   <= ST_WACK;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rnw) begin
                                shreg  <= status_byte;
                                sda_oe <= ~status_byte[BYTE_W-1];
                                state  <= ST_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WR;
                            end
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_HOLD;
                        end
                    end
                    ST_RD: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bit_cnt == LAST_BIT) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise && sda_lvl) begin
                            state <= ST_HOLD;
                        end else if (scl_fall) begin
                            bit_cnt <= '0;
                            shreg   <= status_byte;
                            sda_oe  <= ~status_byte[BYTE_W-1];
                            state   <= ST_RD;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8: the SDA drive changes only while SCL is low.
    p_sda_change_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl);

    // R5: a host NACK on a read byte leaves the bus released and the target idle.
    p_nack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK && scl_rise && sda_lvl && !start_det && !stop_det)
        |=> (!sda_oe && state == ST_HOLD));

    // R6: a STOP abandons the transfer, releases SDA and issues no commit.
    p_stop_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && !wr_en && state == ST_IDLE));

    // R7: an idle target never holds SDA low.
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_HOLD || state == ST_ADDR) |-> !sda_oe);
endmodule

// File: rtl/ctl_status_reg.sv
// Module: ctl_status_reg
// Holds the control field and assembles the status byte. The byte combines
// the synchronised fault monitors with an echo of the low control bits.
// Assumes the monitors are asynchronous levels.
module ctl_status_reg
    import supply_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              ot_mon,
    input  logic              ol_mon,
    output logic [CTL_W-1:0]  ctl_q,
    output logic [BYTE_W-1:0] status_byte
);
    logic [1:0] ot_ff, ol_ff;

    // Control register: loads the low bits of a committed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else if (wr_en) ctl_q <= wr_data[CTL_W-1:0];
    end

    // Two-stage synchronisers for the fault monitors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ot_ff <= '0;
            ol_ff <= '0;
        end else begin
            ot_ff <= {ot_ff[0], ot_mon};
            ol_ff <= {ol_ff[0], ol_mon};
        end
    end

    // Status byte assembly; bits above the overload flag read as 0.
    always_comb begin
        status_byte                 = '0;
        status_byte[ECHO_W-1:0]     = ctl_q[ECHO_W-1:0];
        status_byte[FLAG_OT]        = ot_ff[1];
        status_byte[FLAG_OL]        = ol_ff[1];
    end

    // R2: a commit loads exactly the low five bits of the byte.
    p_commit_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctl_q == $past(wr_data[CTL_W-1:0])));

    // R6: the control field never moves without a commit.
    p_ctl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctl_q));
endmodule

// File: rtl/supply_ctl_i2c_target.sv
// Module: supply_ctl_i2c_target
// Top level for one section: synchroniser, protocol engine and register.
// SECTION (0 or 1) fixes the address pair. The strap picks one address
// of the pair. SDA is open drain: sda_oe_o high pulls the line low.
module supply_ctl_i2c_target #(
    parameter bit SECTION = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o,
    input  logic addr_strap_i,
    input  logic ot_mon_i,
    input  logic ol_mon_i,
    output logic out_en_o,
    output logic out_vsel_o,
    output logic out_llc_o,
    output logic out_ttx_o,
    output logic out_ten_o
);
    import supply_ctl_pkg::*;

    localparam logic [6:0] ADDR_BASE = 7'h08 | {5'b0, SECTION, 1'b0};

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data, status_byte;
    logic [CTL_W-1:0]  ctl_q;
    logic [6:0]        dev_addr;

    // Device address from the section base and the strap.
    always_comb dev_addr = ADDR_BASE | {6'b0, addr_strap_i};

    bus_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    target_byte_engine u_engine (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .dev_addr(dev_addr), .status_byte(status_byte),
        .sda_oe(sda_oe_o), .wr_en(wr_en), .wr_data(wr_data)
    );

    ctl_status_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ot_mon(ot_mon_i), .ol_mon(ol_mon_i), .ctl_q(ctl_q),
        .status_byte(status_byte)
    );

    // Control outputs straight from the register.
    always_comb {out_ten_o, out_ttx_o, out_llc_o, out_vsel_o, out_en_o} = ctl_q;
endmodule

// File: tb/supply_ctl_i2c_target_tb_top.sv
// Bench: two targets (section 0 and section 1) on one wired-AND bus,
// driven by a bit-level host model. All expected values come from the
// requirement text.
module supply_ctl_i2c_target_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_scl_low = 1'b0, host_sda_low = 1'b0;
    logic strap_a = 1'b0, strap_b = 1'b0;
    logic ot_a = 1'b0, ol_a = 1'b0;
    logic oe_a, oe_b;
    logic en_a, vs_a, llc_a, ttx_a, ten_a;
    logic en_b, vs_b, llc_b, ttx_b, ten_b;
    logic scl_line, sda_line;
    int   n_checks = 0, n_errors = 0, r8_viol = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign scl_line = ~host_scl_low;
    assign sda_line = ~(host_sda_low | oe_a | oe_b);

    supply_ctl_i2c_target #(.SECTION(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .sda_oe_o(oe_a), .addr_strap_i(strap_a), .ot_mon_i(ot_a), .ol_mon_i(ol_a),
        .out_en_o(en_a), .out_vsel_o(vs_a), .out_llc_o(llc_a),
        .out_ttx_o(ttx_a), .out_ten_o(ten_a));

    supply_ctl_i2c_target #(.SECTION(1'b1)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .sda_oe_o(oe_b), .addr_strap_i(strap_b), .ot_mon_i(1'b0), .ol_mon_i(1'b0),
        .out_en_o(en_b), .out_vsel_o(vs_b), .out_llc_o(llc_b),
        .out_ttx_o(ttx_b), .out_ten_o(ten_b));

    function automatic logic [4:0] ctl_a();
        return {ten_a, ttx_a, llc_a, vs_a, en_a};
    endfunction
    function automatic logic [4:0] ctl_b();
        return {ten_b, ttx_b, llc_b, vs_b, en_b};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // R8 monitor: SDA drive must not move while SCL is high.
    logic prev_oe_a = 1'b0, prev_oe_b = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl_line && (oe_a != prev_oe_a || oe_b != prev_oe_b)) r8_viol++;
        prev_oe_a <= oe_a;
        prev_oe_b <= oe_b;
    end

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        host_sda_low = 1'b0; wq();
        host_scl_low = 1'b0; wq();
        host_sda_low = 1'b1; wq();
        host_scl_low = 1'b1; wq();
    endtask

    task automatic bus_stop();
        host_sda_low = 1'b1; wq();
        host_scl_low = 1'b0; wq();
        host_sda_low = 1'b0; wq(); wq();
    endtask

    task automatic send_bit(input logic b);
        host_sda_low = ~b; wq();
        host_scl_low = 1'b0; wq(); wq();
        host_scl_low = 1'b1; wq();
    endtask

    task automatic recv_bit(output logic b);
        host_sda_low = 1'b0; wq();
        host_scl_low = 1'b0; wq();
        b = sda_line; wq();
        host_scl_low = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(s);
        ack = ~s;
    endtask

    task automatic do_write(input logic [7:0] a8, input logic [7:0] d,
                            output logic aack, output logic dack);
        bus_start();
        send_byte(a8, aack);
        dack = 1'b0;
        if (aack) send_byte(d, dack);
        bus_stop();
    endtask

    // Read one byte, NACK it, then check that the target released SDA (R5).
    task automatic do_read(input logic [7:0] a8, output logic aack, output logic [7:0] d);
        logic b;
        bus_start();
        send_byte(a8, aack);
        d = 8'h00;
        if (aack) begin
            for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
            send_bit(1'b1);
            host_sda_low = 1'b0; wq();
            chk("R5 SDA released after NACK", {31'b0, sda_line}, 32'd1);
        end
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        logic aa, da;
        logic [7:0] rd, wv;
        logic b;
        repeat (5) @(negedge clk);
        // R7: reset state.
        chk("R7 reset ctl A", {27'b0, ctl_a()}, 32'd0);
        chk("R7 reset ctl B", {27'b0, ctl_b()}, 32'd0);
        chk("R7 reset SDA released", {30'b0, oe_a, oe_b}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2/R3: all 32 control values with junk in bits 7:5, read back each.
        for (int v = 0; v < 32; v++) begin
            wv = {3'(v * 5 + 3), 5'(v)};
            do_write(8'h10, wv, aa, da);
            chk("R1 address ACK 0x10", {31'b0, aa}, 32'd1);
            chk("R2 data ACK", {31'b0, da}, 32'd1);
            chk("R2 control outputs, bits 7:5 ignored", {27'b0, ctl_a()}, 32'(v));
            chk("R1 section B untouched", {27'b0, ctl_b()}, 32'd0);
            do_read(8'h11, aa, rd);
            chk("R3 status echo, upper bits 0", {24'b0, rd}, 32'(v & 7));
        end

        // R1: every strap setting against all four addresses plus one foreign address.
        for (int s = 0; s < 2; s++) begin
            strap_a = 1'(s); strap_b = 1'(s);
            repeat (4) @(negedge clk);
            for (int k = 0; k < 5; k++) begin
                logic exp_a, exp_b;
                logic [4:0] pa, pb;
                pa = ctl_a(); pb = ctl_b();
                wv = 8'(5'(k * 7 + s * 3 + 1));
                do_write(8'(8'h10 + 2 * k), wv, aa, da);
                exp_a = (k == s);
                exp_b = (k == 2 + s);
                chk("R1 ACK iff address matches", {31'b0, aa}, {31'b0, exp_a | exp_b});
                chk("R1 section A write routing", {27'b0, ctl_a()}, {27'b0, exp_a ? wv[4:0] : pa});
                chk("R1 section B write routing", {27'b0, ctl_b()}, {27'b0, exp_b ? wv[4:0] : pb});
                do_read(8'(8'h11 + 2 * k), aa, rd);
                chk("R1 read ACK iff address matches", {31'b0, aa}, {31'b0, exp_a | exp_b});
                if (exp_b) chk("R3 section B status", {24'b0, rd}, {29'b0, wv[2:0]});
            end
        end
        strap_a = 1'b0; strap_b = 1'b0;
        repeat (4) @(negedge clk);

        // R4: all four monitor combinations, flags in bits 3 and 4.
        do_write(8'h10, 8'h05, aa, da);
        for (int f = 0; f < 4; f++) begin
            ot_a = f[0]; ol_a = f[1];
            repeat (6) @(negedge clk);
            do_read(8'h11, aa, rd);
            chk("R4 fault flags in status", {24'b0, rd}, 32'(5 + 8 * f));
        end
        ot_a = 1'b0; ol_a = 1'b0;
        repeat (6) @(negedge clk);

        // R6: STOP after four data bits leaves the register alone.
        do_write(8'h10, 8'h0A, aa, da);
        bus_start();
        send_byte(8'h10, aa);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        chk("R6 STOP mid-byte keeps register", {27'b0, ctl_a()}, 32'h0A);

        // R6: repeated START after seven data bits, then read in the same transfer.
        bus_start();
        send_byte(8'h10, aa);
        for (int i = 0; i < 7; i++) send_bit(1'b1);
        bus_start();
        send_byte(8'h11, aa);
        chk("R6 ACK after repeated START", {31'b0, aa}, 32'd1);
        rd = 8'h00;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); rd[i] = b; end
        send_bit(1'b1);
        bus_stop();
        chk("R6 repeated START keeps register", {24'b0, rd}, 32'h02);
        chk("R6 outputs unchanged", {27'b0, ctl_a()}, 32'h0A);

        // R7: reset during operation clears outputs.
        do_write(8'h10, 8'h1F, aa, da);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 reset clears ctl", {27'b0, ctl_a()}, 32'd0);
        chk("R7 reset releases SDA", {31'b0, oe_a}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        chk("R8 SDA drive changes only with SCL low", r8_viol, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule